// File: doc/BRIEF.md
# Serial Divider-Configuration Scan Chain

This block holds the settings of a small bank of clock dividers and lets them be replaced while the dividers keep running. A new configuration image is fed in one bit at a time on a serial input, clocked by a scan clock and gated by a scan-enable. A rising edge on the update strobe copies the shifted image into a shadow register and sends an update request to every divider. Each divider takes its new setting on its own clock, at the end of the period it is currently producing, so the dividers switch at different moments and no output pulse is ever cut short or stretched. The charge-pump and loop-filter codes travel in the same image and come out as plain code outputs.

There are ten dividers: a pre-scale divider clocked by the reference clock, and a feedback divider, a post-oscillator divider and seven output dividers, all clocked by the oscillator clock. A divider field gives a high count, a low count, a bypass bit and an odd-duty bit. The serial output presents the bit pushed off the far end of the chain, so shifting in a new image reads back the old one. A done flag rises once every divider and the code register have taken the new image, and drops again at the next update strobe. The serial port is a gated shift register with no back-pressure: every enabled scan-clock edge consumes one bit, and the scan clock is meant to run at up to 100 MHz.

Top module: `divcfg_scan_chain`

## Requirements
- R1: On each rising scan_clk edge with scan_en high the chain shifts by one bit, taking scan_din in at bit 0; scan_dout always shows bit 189, so shifting a full 190-bit image out presents the previous image, first-shifted bit first.
- R2: With scan_en low the chain keeps its contents whatever scan_din does; scan_dout stays unchanged and a shift that resumes after a pause ends with the same image as an uninterrupted one.
- R3: A rising edge of update copies the chain into the active configuration; shifting without an update leaves cp_code, lf_r, lf_c and all divider outputs unchanged; once done is high the code outputs equal the updated image.
- R4: Chain bit positions, counting the bit shifted last as bit 0: output divider Ci at [18*(6-i)+17 : 18*(6-i)], loop-filter C code [127:126], loop-filter R code [132:128], post-oscillator divider [150:133], charge-pump code [153:151], feedback divider [171:154], pre-scale divider [189:172]. Each divider field is bypass [17], odd-duty [16], high count [15:8], low count [7:0].
- R5: With bypass 0, high count h not 0 and odd-duty 1, a divider output is high for h and low for l input-clock cycles.
- R6: With bypass 0, high count h not 0 and odd-duty 0, a divider output is high for h and low for h cycles; the low count has no effect.
- R7: A divider with bypass 1, or with a high count of 0, passes its input clock straight to its output.
- R8: A divider loads a new setting only at the end of its current period, in its own clock domain; across a change every high and low run has the length of either the old or the new setting.
- R9: done drops in the scan_clk cycle after an update edge and rises once all dividers and the code register have taken the new image; it then stays high until the next update edge.
- R10: After reset every divider is in pass-through, cp_code, lf_r and lf_c are 0, scan_dout is 0 and done is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| scan_clk | input | 1 | Scan clock for shifting and update |
| ref_clk | input | 1 | Reference clock for the pre-scale divider |
| osc_clk | input | 1 | Oscillator clock for the other nine dividers and the code register |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| scan_en | input | 1 | Shift enable |
| scan_din | input | 1 | Serial configuration data in |
| update | input | 1 | Update strobe, acted on at its rising edge |
| scan_dout | output | 1 | Bit leaving the far end of the chain |
| done | output | 1 | All units have taken the last update |
| out_clk | output | 7 | Output divider clocks C0 to C6 |
| pre_clk | output | 1 | Pre-scale divider output |
| fb_clk | output | 1 | Feedback divider output |
| vco_div_clk | output | 1 | Post-oscillator divider output |
| cp_code | output | 3 | Active charge-pump code |
| lf_r | output | 5 | Active loop-filter resistor code |
| lf_c | output | 2 | Active loop-filter capacitor code |

## Verification
The divider settings are tried as a table of odd-duty and symmetric patterns, including 1/1, long-high/short-low and a nonzero low count in symmetric mode, which separates the two duty modes and catches a swapped high and low count. An image with a different setting in every field tells apart a misplaced or misordered field, and bypass and zero-high-count fields separate pass-through from division. A shift paused mid-image with scan_din toggling distinguishes a true hold from a leaky enable, and a slow-to-fast change on one output, watched run by run, exposes any update that lands mid-period.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int HC_W     = 8;
  localparam int DIV_W    = 2 * HC_W + 2;
  localparam int NUM_POST = 7;
  localparam int CP_W     = 3;
  localparam int LFR_W    = 5;
  localparam int LFC_W    = 2;
  localparam int NUM_DIV  = NUM_POST + 3;
  localparam int NUM_ACK  = NUM_DIV + 1;
  localparam int IDX_N    = NUM_POST;
  localparam int IDX_M    = NUM_POST + 1;
  localparam int IDX_K    = NUM_POST + 2;
  localparam int CHAIN_W  = NUM_DIV * DIV_W + CP_W + LFR_W + LFC_W;
  // Field offsets: the post-oscillator field sits between the pump and filter codes
  localparam int OFS_LFC  = NUM_POST * DIV_W;
  localparam int OFS_LFR  = OFS_LFC + LFC_W;
  localparam int OFS_K    = OFS_LFR + LFR_W;
  localparam int OFS_CP   = OFS_K + DIV_W;
  localparam int OFS_M    = OFS_CP + CP_W;
  localparam int OFS_N    = OFS_M + DIV_W;

  typedef struct packed {
    logic            bypass;
    logic            odd;
    logic [HC_W-1:0] hi;
    logic [HC_W-1:0] lo;
  } div_cfg_t;

  localparam div_cfg_t DIV_RESET = '{bypass: 1'b1, odd: 1'b0, hi: '0, lo: '0};

  function automatic int div_ofs(input int idx);
    if (idx < NUM_POST) return (NUM_POST - 1 - idx) * DIV_W;
    else if (idx == IDX_N) return OFS_N;
    else if (idx == IDX_M) return OFS_M;
    else return OFS_K;
  endfunction
endpackage

// File: rtl/dcs_bit_sync.sv
module dcs_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= '0;
    else        ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/dcs_scan_ctrl.sv
module dcs_scan_ctrl
  import dcs_pkg::*;
(
  input  logic               scan_clk,
  input  logic               rst_n,
  input  logic               scan_en,
  input  logic               scan_din,
  input  logic               update,
  input  logic [NUM_ACK-1:0] ack_tgl,
  output logic               scan_dout,
  output logic [CHAIN_W-1:0] shadow,
  output logic               req,
  output logic               done
);
  logic [CHAIN_W-1:0] chain_q;
  logic [NUM_ACK-1:0] ack_s;
  logic               upd_q;
  logic               started;
  logic               upd_rise;
  logic               all_ack;

  for (genvar a = 0; a < NUM_ACK; a++) begin : g_ack
    dcs_bit_sync #(.STAGES(2)) u_sync (
      .clk  (scan_clk),
      .rst_n(rst_n),
      .d    (ack_tgl[a]),
      .q    (ack_s[a])
    );
  end

  assign upd_rise = update & ~upd_q;
  assign all_ack  = (ack_s == {NUM_ACK{req}});

  always_ff @(posedge scan_clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      shadow  <= '0;
      upd_q   <= 1'b0;
      req     <= 1'b0;
      started <= 1'b0;
      done    <= 1'b0;
    end else begin
      upd_q <= update;
      if (scan_en) chain_q <= {chain_q[CHAIN_W-2:0], scan_din};
      if (upd_rise) begin
        shadow  <= chain_q;
        req     <= ~req;
        started <= 1'b1;
        done    <= 1'b0;
      end else begin
        done <= started & all_ack;
      end
    end
  end

  assign scan_dout = chain_q[CHAIN_W-1];
endmodule

// File: rtl/dcs_divider.sv
module dcs_divider
  import dcs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req,
  input  div_cfg_t cfg_in,
  output logic     clk_out,
  output logic     ack
);
  localparam int CNT_W = HC_W + 1;

  div_cfg_t         act, act_nx;
  logic [CNT_W-1:0] cnt, cnt_nx, period;
  logic             req_s, pending, thru, tc, take, div_q;

  dcs_bit_sync #(.STAGES(2)) u_req_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (req),
    .q    (req_s)
  );

  assign thru    = act.bypass | (act.hi == '0);
  assign period  = act.odd ? ({1'b0, act.hi} + {1'b0, act.lo}) : {act.hi, 1'b0};
  assign tc      = (cnt == period - 1'b1);
  assign pending = req_s ^ ack;
  assign take    = pending & (thru | tc);

  always_comb begin
    act_nx = act;
    cnt_nx = cnt;
    if (take) begin
      act_nx = cfg_in;
      cnt_nx = '0;
    end else if (!thru) begin
      cnt_nx = tc ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act   <= DIV_RESET;
      cnt   <= '0;
      ack   <= 1'b0;
      div_q <= 1'b0;
    end else begin
      act   <= act_nx;
      cnt   <= cnt_nx;
      div_q <= (cnt_nx < {1'b0, act_nx.hi});
      if (take) ack <= req_s;
    end
  end

  assign clk_out = thru ? clk : div_q;
endmodule

// File: rtl/dcs_code_apply.sv
module dcs_code_apply
  import dcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [CP_W-1:0]  cp_in,
  input  logic [LFR_W-1:0] lfr_in,
  input  logic [LFC_W-1:0] lfc_in,
  output logic [CP_W-1:0]  cp_code,
  output logic [LFR_W-1:0] lf_r,
  output logic [LFC_W-1:0] lf_c,
  output logic             ack
);
  logic req_s;

  dcs_bit_sync #(.STAGES(2)) u_req_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (req),
    .q    (req_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_code <= '0;
      lf_r    <= '0;
      lf_c    <= '0;
      ack     <= 1'b0;
    end else if (req_s != ack) begin
      cp_code <= cp_in;
      lf_r    <= lfr_in;
      lf_c    <= lfc_in;
      ack     <= req_s;
    end
  end
endmodule

// File: rtl/divcfg_scan_chain.sv
module divcfg_scan_chain
  import dcs_pkg::*;
(
  input  logic                scan_clk,
  input  logic                ref_clk,
  input  logic                osc_clk,
  input  logic                rst_n,
  input  logic                scan_en,
  input  logic                scan_din,
  input  logic                update,
  output logic                scan_dout,
  output logic                done,
  output logic [NUM_POST-1:0] out_clk,
  output logic                pre_clk,
  output logic                fb_clk,
  output logic                vco_div_clk,
  output logic [CP_W-1:0]     cp_code,
  output logic [LFR_W-1:0]    lf_r,
  output logic [LFC_W-1:0]    lf_c
);
  logic [CHAIN_W-1:0] shadow;
  logic               req;
  logic [NUM_ACK-1:0] ack_tgl;
  logic [NUM_DIV-1:0] div_clk;

  dcs_scan_ctrl u_scan (
    .scan_clk (scan_clk),
    .rst_n    (rst_n),
    .scan_en  (scan_en),
    .scan_din (scan_din),
    .update   (update),
    .ack_tgl  (ack_tgl),
    .scan_dout(scan_dout),
    .shadow   (shadow),
    .req      (req),
    .done     (done)
  );

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    localparam int OFS = div_ofs(g);
    if (g == IDX_N) begin : g_ref
      dcs_divider u_div (
        .clk    (ref_clk),
        .rst_n  (rst_n),
        .req    (req),
        .cfg_in (div_cfg_t'(shadow[OFS +: DIV_W])),
        .clk_out(div_clk[g]),
        .ack    (ack_tgl[g])
      );
    end else begin : g_osc
      dcs_divider u_div (
        .clk    (osc_clk),
        .rst_n  (rst_n),
        .req    (req),
        .cfg_in (div_cfg_t'(shadow[OFS +: DIV_W])),
        .clk_out(div_clk[g]),
        .ack    (ack_tgl[g])
      );
    end
  end

  dcs_code_apply u_codes (
    .clk    (osc_clk),
    .rst_n  (rst_n),
    .req    (req),
    .cp_in  (shadow[OFS_CP +: CP_W]),
    .lfr_in (shadow[OFS_LFR +: LFR_W]),
    .lfc_in (shadow[OFS_LFC +: LFC_W]),
    .cp_code(cp_code),
    .lf_r   (lf_r),
    .lf_c   (lf_c),
    .ack    (ack_tgl[NUM_DIV])
  );

  assign out_clk     = div_clk[NUM_POST-1:0];
  assign pre_clk     = div_clk[IDX_N];
  assign fb_clk      = div_clk[IDX_M];
  assign vco_div_clk = div_clk[IDX_K];
endmodule

// File: rtl/dcs_chain_checker.sv
module dcs_chain_checker
  import dcs_pkg::*;
(
  input logic               scan_clk,
  input logic               rst_n,
  input logic               scan_en,
  input logic               update,
  input logic               scan_dout,
  input logic               done,
  input logic [CP_W-1:0]    cp_code,
  input logic [LFR_W-1:0]   lf_r,
  input logic [LFC_W-1:0]   lf_c,
  input logic [CHAIN_W-1:0] shadow,
  input logic               req
);
  AST_DOUT_HOLD: assert property (@(posedge scan_clk) disable iff (!rst_n)
    !scan_en |=> $stable(scan_dout)); // R2

  AST_REQ_FLIP: assert property (@(posedge scan_clk) disable iff (!rst_n)
    $rose(update) |=> (req != $past(req))); // R3

  AST_CODES_MATCH: assert property (@(posedge scan_clk) disable iff (!rst_n)
    done |-> (cp_code == shadow[OFS_CP +: CP_W] && lf_r == shadow[OFS_LFR +: LFR_W]
              && lf_c == shadow[OFS_LFC +: LFC_W])); // R3

  AST_DONE_CLEAR: assert property (@(posedge scan_clk) disable iff (!rst_n)
    $rose(update) |=> !done); // R9

  AST_DONE_STICKY: assert property (@(posedge scan_clk) disable iff (!rst_n)
    (done && !$rose(update)) |=> done); // R9
endmodule

bind divcfg_scan_chain dcs_chain_checker u_chk (
  .scan_clk (scan_clk),
  .rst_n    (rst_n),
  .scan_en  (scan_en),
  .update   (update),
  .scan_dout(scan_dout),
  .done     (done),
  .cp_code  (cp_code),
  .lf_r     (lf_r),
  .lf_c     (lf_c),
  .shadow   (shadow),
  .req      (req)
);

// File: tb/tb_divcfg_scan_chain.sv
module tb_divcfg_scan_chain;
  localparam int W  = 190;
  localparam int FW = 18;

  typedef struct packed {
    logic [FW-1:0] cfg;
    logic [7:0]    eh;
    logic [7:0]    el;
    logic [3:0]    idx;
  } vec_t;

  // cfg = {bypass, odd, hi[7:0], lo[7:0]}
  localparam vec_t VECS [7] = '{
    '{{1'b0, 1'b1, 8'd3,  8'd5}, 8'd3,  8'd5, 4'd0},
    '{{1'b0, 1'b1, 8'd1,  8'd1}, 8'd1,  8'd1, 4'd1},
    '{{1'b0, 1'b0, 8'd4,  8'd9}, 8'd4,  8'd4, 4'd2},
    '{{1'b0, 1'b1, 8'd7,  8'd2}, 8'd7,  8'd2, 4'd3},
    '{{1'b0, 1'b0, 8'd1,  8'd0}, 8'd1,  8'd1, 4'd4},
    '{{1'b0, 1'b1, 8'd10, 8'd1}, 8'd10, 8'd1, 4'd6},
    '{{1'b0, 1'b0, 8'd6,  8'd3}, 8'd6,  8'd6, 4'd5}
  };

  logic scan_clk = 1'b0, osc_clk = 1'b0, ref_clk = 1'b0;
  always #5  scan_clk = ~scan_clk;
  always #4  osc_clk  = ~osc_clk;
  always #10 ref_clk  = ~ref_clk;

  logic       rst_n, scan_en, scan_din, update;
  logic       scan_dout, done, pre_clk, fb_clk, vco_div_clk;
  logic [6:0] out_clk;
  logic [2:0] cp_code;
  logic [4:0] lf_r;
  logic [1:0] lf_c;

  divcfg_scan_chain dut (
    .scan_clk(scan_clk), .ref_clk(ref_clk), .osc_clk(osc_clk), .rst_n(rst_n),
    .scan_en(scan_en), .scan_din(scan_din), .update(update),
    .scan_dout(scan_dout), .done(done), .out_clk(out_clk), .pre_clk(pre_clk),
    .fb_clk(fb_clk), .vco_div_clk(vco_div_clk), .cp_code(cp_code),
    .lf_r(lf_r), .lf_c(lf_c)
  );

  int checks = 0, errors = 0;
  logic [W-1:0]  seen, last_img, img;
  logic [FW-1:0] cur [10];

  // run monitor on out_clk[0] for R8
  logic mon_on = 1'b0, mon_armed = 1'b0, mon_prev = 1'b0;
  int   mon_run = 0, mon_bad = 0, mon_short = 0;

  always @(negedge osc_clk) begin
    if (mon_on) begin
      if (out_clk[0] !== mon_prev) begin
        if (mon_armed) begin
          if (!(mon_run == 20 || mon_run == 3)) mon_bad++;
          if (mon_run == 3) mon_short++;
        end
        mon_armed = 1'b1;
        mon_run   = 1;
      end else begin
        mon_run++;
      end
      mon_prev = out_clk[0];
    end
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int fofs(input int i);
    if (i < 7) return (6 - i) * FW;
    else if (i == 7) return 172;
    else if (i == 8) return 154;
    else return 133;
  endfunction

  function automatic logic [FW-1:0] mk(input logic b, input logic o, input int h, input int l);
    return {b, o, 8'(h), 8'(l)};
  endfunction

  function automatic logic [W-1:0] build(input logic [FW-1:0] d [10], input logic [2:0] cp,
                                         input logic [4:0] r, input logic [1:0] c);
    logic [W-1:0] v = '0;
    for (int i = 0; i < 10; i++) v[fofs(i) +: FW] = d[i];
    v[153:151] = cp;
    v[132:128] = r;
    v[127:126] = c;
    return v;
  endfunction

  function automatic logic sig(input int sel);
    if (sel < 7) return out_clk[sel];
    else if (sel == 7) return pre_clk;
    else if (sel == 8) return fb_clk;
    else return vco_div_clk;
  endfunction

  task automatic negclk(input int sel);
    if (sel == 7) @(negedge ref_clk);
    else @(negedge osc_clk);
  endtask

  task automatic shift_range(input logic [W-1:0] v, input int top, input int bot);
    for (int b = top; b >= bot; b--) begin
      scan_din = v[b];
      scan_en  = 1'b1;
      seen[b]  = scan_dout;
      @(posedge scan_clk); #2;
    end
    scan_en = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 4000) begin
      @(posedge scan_clk); #2;
      n++;
    end
    chk(done == 1'b1, "R9 done after update", done, 1);
  endtask

  task automatic strobe();
    update = 1'b1;
    @(posedge scan_clk); #2;
    chk(done == 1'b0, "R9 done cleared", done, 0);
    update = 1'b0;
    wait_done();
  endtask

  task automatic load(input logic [W-1:0] v);
    shift_range(v, W - 1, 0);
    chk(seen == last_img, "R1 readback", $countones(seen ^ last_img), 0);
    last_img = v;
    strobe();
  endtask

  task automatic runs(input int sel, output int h, output int l);
    int g = 0;
    h = 0; l = 0;
    do begin negclk(sel); g++; end while (sig(sel) !== 1'b0 && g < 3000);
    do begin negclk(sel); g++; end while (sig(sel) !== 1'b1 && g < 3000);
    h = 1;
    forever begin negclk(sel); if (sig(sel) === 1'b1 && g++ < 3000) h++; else break; end
    l = 1;
    forever begin negclk(sel); if (sig(sel) === 1'b0 && g++ < 3000) l++; else break; end
  endtask

  task automatic period_chk(input int sel, input int eh, input int el, input string rq);
    int h, l;
    runs(sel, h, l);
    chk(h == eh, rq, h, eh);
    chk(l == el, rq, l, el);
  endtask

  task automatic thru_chk(input int sel, input string rq);
    if (sel == 7) @(posedge ref_clk); else @(posedge osc_clk);
    #1 chk(sig(sel) === 1'b1, rq, sig(sel), 1);
    negclk(sel);
    #1 chk(sig(sel) === 1'b0, rq, sig(sel), 0);
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic d0;
    int   bad;
    logic [2:0] pcp;
    rst_n = 1'b0; scan_en = 1'b0; scan_din = 1'b0; update = 1'b0;
    last_img = '0; seen = '0;
    repeat (3) @(posedge scan_clk);
    #2 rst_n = 1'b1;
    @(posedge scan_clk); #2;

    // R10 reset state
    chk(done == 1'b0, "R10 done", done, 0);
    chk(cp_code == 3'd0, "R10 cp", cp_code, 0);
    chk(lf_r == 5'd0 && lf_c == 2'd0, "R10 lf", {lf_r, lf_c}, 0);
    chk(scan_dout == 1'b0, "R10 dout", scan_dout, 0);
    thru_chk(0, "R10 C0 pass-through");
    thru_chk(7, "R10 pre pass-through");
    thru_chk(8, "R10 fb pass-through");

    // table of divider settings, R5 / R6 / R1 / R3
    pcp = 3'd0;
    for (int v = 0; v < 7; v++) begin
      for (int i = 0; i < 7; i++) cur[i] = VECS[v].cfg;
      for (int i = 7; i < 10; i++) cur[i] = mk(1'b1, 1'b0, 0, 0);
      img = build(cur, 3'(v + 1), 5'(3 * v + 1), 2'(v));
      shift_range(img, W - 1, 0);
      chk(seen == last_img, "R1 readback", $countones(seen ^ last_img), 0);
      chk(cp_code == pcp, "R3 no change before update", cp_code, pcp);
      last_img = img;
      strobe();
      chk(cp_code == 3'(v + 1), "R3 cp", cp_code, v + 1);
      chk(lf_r == 5'(3 * v + 1), "R3 lf_r", lf_r, 3 * v + 1);
      chk(lf_c == 2'(v), "R3 lf_c", lf_c, v % 4);
      period_chk(int'(VECS[v].idx), int'(VECS[v].eh), int'(VECS[v].el),
                 VECS[v].cfg[16] ? "R5 odd-duty runs" : "R6 symmetric runs");
      pcp = 3'(v + 1);
    end

    // R4 field layout with a distinct setting per field, R7 pass-through cases
    cur[0] = mk(1'b0, 1'b1, 2, 1);
    cur[1] = mk(1'b1, 1'b0, 0, 0);
    cur[2] = mk(1'b1, 1'b1, 5, 5);
    cur[3] = mk(1'b1, 1'b0, 0, 0);
    cur[4] = mk(1'b0, 1'b1, 0, 6);
    cur[5] = mk(1'b1, 1'b0, 0, 0);
    cur[6] = mk(1'b0, 1'b1, 4, 4);
    cur[7] = mk(1'b0, 1'b1, 2, 2);
    cur[8] = mk(1'b0, 1'b0, 3, 0);
    cur[9] = mk(1'b0, 1'b1, 5, 1);
    load(build(cur, 3'd2, 5'd17, 2'd1));
    period_chk(0, 2, 1, "R4 C0 field");
    period_chk(6, 4, 4, "R4 C6 field");
    period_chk(7, 2, 2, "R4 pre-scale field");
    period_chk(8, 3, 3, "R4 feedback field");
    period_chk(9, 5, 1, "R4 post-osc field");
    chk(cp_code == 3'd2 && lf_r == 5'd17 && lf_c == 2'd1, "R4 code fields",
        {cp_code, lf_r, lf_c}, {3'd2, 5'd17, 2'd1});
    thru_chk(2, "R7 bypass bit");
    thru_chk(4, "R7 zero high count");

    // R2 pause in the middle of a shift
    cur[0] = mk(1'b0, 1'b1, 2, 2);
    img = build(cur, 3'd6, 5'd21, 2'd3);
    shift_range(img, W - 1, 100);
    d0 = scan_dout;
    bad = 0;
    for (int k = 0; k < 16; k++) begin
      scan_din = k[0];
      @(posedge scan_clk); #2;
      if (scan_dout !== d0) bad++;
    end
    chk(bad == 0, "R2 dout held while disabled", bad, 0);
    shift_range(img, 99, 0);
    chk(seen == last_img, "R2 readback after pause", $countones(seen ^ last_img), 0);
    last_img = img;
    strobe();
    chk(cp_code == 3'd6 && lf_r == 5'd21 && lf_c == 2'd3, "R2 image intact",
        {cp_code, lf_r, lf_c}, {3'd6, 5'd21, 2'd3});
    period_chk(0, 2, 2, "R2 divider intact");

    // R8 change from a long to a short period while watching every run
    cur[0] = mk(1'b0, 1'b1, 20, 20);
    load(build(cur, 3'd6, 5'd21, 2'd3));
    period_chk(0, 20, 20, "R5 long period");
    mon_armed = 1'b0;
    mon_on    = 1'b1;
    cur[0] = mk(1'b0, 1'b1, 3, 3);
    load(build(cur, 3'd6, 5'd21, 2'd3));
    repeat (100) @(negedge osc_clk);
    mon_on = 1'b0;
    chk(mon_bad == 0, "R8 no partial runs", mon_bad, 0);
    chk(mon_short > 0, "R8 new period reached", mon_short, 1);

    // R9 done stays high with no new strobe
    bad = 0;
    for (int k = 0; k < 50; k++) begin
      @(posedge scan_clk); #2;
      if (done !== 1'b1) bad++;
    end
    chk(bad == 0, "R9 done holds", bad, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule